// File: doc/BRIEF.md
# FIFO Trigger-Level Interrupt Generator

This block turns the occupancy counts of a serial port's two FIFOs into three interrupt conditions. The transmit side reports a transmit-ready condition when enough free space has opened in the TX FIFO. The receive side reports a data-ready condition when enough characters have gathered in the RX FIFO. Each side compares its count against a trigger level taken from one nibble of an 8-bit trigger register. A nonzero nibble selects a fine-grained level in steps of four. A zero nibble hands the choice back to a coarse 2-bit selection held in the FIFO-control register.

A third condition, the receive timeout, does not depend on any trigger level. It is raised when the RX FIFO holds at least one character and the receive line has stayed idle for four character times. A strobe from the receiver marks each idle character time. The count restarts whenever a character arrives or the FIFO is read, and it clears when the FIFO runs empty. The block drives only the three flags. Priority encoding of interrupts belongs to a neighbouring block.

Top module: `fifo_trig_irq`

## Requirements
- R1: When trig_reg[3:0] is nonzero, the TX trigger level equals that nibble times 4, so it ranges from 4 to 60.
- R2: When trig_reg[7:4] is nonzero, the RX trigger level equals that nibble times 4, so it ranges from 4 to 60.
- R3: tx_ready_irq is 1 in the cycle after the TX free-space count is greater than or equal to the TX trigger level, and it is 0 otherwise.
- R4: rx_ready_irq is 1 in the cycle after the RX fill count is greater than or equal to the RX trigger level, and it is 0 otherwise.
- R5: When trig_reg[3:0] is zero, the TX level comes from fifo_ctl[5:4], with 00, 01, 10 and 11 mapping to 8, 16, 32 and 56.
- R6: When trig_reg[7:4] is zero, the RX level comes from fifo_ctl[7:6], with 00, 01, 10 and 11 mapping to 8, 16, 56 and 60.
- R7: rx_timeout_irq becomes 1 in the cycle after the 4th idle strobe that is counted while rx_fill is nonzero and no character arrives and no read happens. The RX trigger level has no effect on it. It then stays 1 until R8 or R9 clears it.
- R8: A cycle with rx_char or rx_read set clears the idle count and drives rx_timeout_irq to 0 in the next cycle.
- R9: A cycle with rx_fill equal to 0 clears the idle count and drives rx_timeout_irq to 0 in the next cycle.
- R10: While rst is 1 at a clock edge, all three interrupt outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_free | input | CNT_W | Free entries in the TX FIFO |
| rx_fill | input | CNT_W | Characters held in the RX FIFO |
| trig_reg | input | 8 | Trigger register: [3:0] TX nibble, [7:4] RX nibble |
| fifo_ctl | input | 8 | FIFO-control register: [5:4] legacy TX select, [7:6] legacy RX select |
| rx_char | input | 1 | A received character was written into the RX FIFO |
| rx_read | input | 1 | The RX FIFO was read |
| idle_tick | input | 1 | One character time passed with the receive line idle |
| tx_ready_irq | output | 1 | Transmit-ready condition |
| rx_ready_irq | output | 1 | Receive-data-ready condition |
| rx_timeout_irq | output | 1 | Receive timeout condition |

## Verification
The in-RTL assertions check several properties on every cycle. Each selected level is a legal multiple of four. Both compare flags follow the count-against-level relation one cycle later. The timeout flag appears only while data is present, a character or read clears it, and an empty FIFO clears it. The timeout flag also holds steady while nothing disturbs it. Other behaviours show up only in the bench's scenarios. These are the exact level decoded for each nibble and for each legacy code, the boundary values on either side of each level, and the fact that the timeout needs exactly four counted strobes regardless of the RX level.

// File: rtl/fti_pkg.sv
package fti_pkg;

  // Fine-grained levels are the nibble shifted left by this amount.
  localparam int TRIG_SHIFT = 2;

  typedef enum logic {SIDE_TX = 1'b0, SIDE_RX = 1'b1} side_e;

  // Coarse TX selection: spaces that must be free.
  function automatic int legacy_tx_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

  // Coarse RX selection: characters that must be present.
  function automatic int legacy_rx_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction

endpackage

// File: rtl/fti_level_sel.sv
module fti_level_sel
  import fti_pkg::*;
#(
  parameter int    CNT_W = 7,
  parameter side_e SIDE  = SIDE_TX
) (
  input  logic [3:0]       nibble,
  input  logic [1:0]       legacy_sel,
  output logic [CNT_W-1:0] level
);

  logic [CNT_W-1:0] fine_lvl;
  logic [CNT_W-1:0] coarse_lvl;

  assign fine_lvl = CNT_W'(nibble) << TRIG_SHIFT;

  generate
    if (SIDE == SIDE_RX) begin : g_rx
      assign coarse_lvl = CNT_W'(legacy_rx_level(legacy_sel));
    end else begin : g_tx
      assign coarse_lvl = CNT_W'(legacy_tx_level(legacy_sel));
    end
  endgenerate

  // R1/R2 fine level wins when nonzero; R5/R6 coarse fallback otherwise.
  assign level = (nibble != 4'd0) ? fine_lvl : coarse_lvl;

endmodule

// File: rtl/fti_cmp.sv
module fti_cmp #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] level,
  output logic             irq
);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (count >= level);
  end

  // R3 / R4: flag follows the threshold relation one cycle later.
  a_r3_cmp_set: assert property (@(posedge clk) disable iff (rst)
    (count >= level) |=> irq);
  a_r3_cmp_clr: assert property (@(posedge clk) disable iff (rst)
    (count < level) |=> !irq);

endmodule

// File: rtl/fti_rx_timeout.sv
module fti_rx_timeout #(
  parameter int CNT_W     = 7,
  parameter int TMO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic             rx_char,
  input  logic             rx_read,
  input  logic             idle_tick,
  output logic             tmo_irq
);

  localparam int TW = $clog2(TMO_CHARS + 1);
  localparam logic [TW-1:0] TMO_V = TW'(TMO_CHARS);

  logic [TW-1:0] idle_q;
  logic [TW-1:0] idle_nx;
  logic          empty;
  logic          restart;

  assign empty   = (rx_fill == '0);
  assign restart = rx_char | rx_read;

  always_comb begin
    if (empty || restart)
      idle_nx = '0;
    else if (idle_tick && (idle_q != TMO_V))
      idle_nx = idle_q + 1'b1;
    else
      idle_nx = idle_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q  <= '0;
      tmo_irq <= 1'b0;
    end else begin
      idle_q  <= idle_nx;
      tmo_irq <= (idle_nx == TMO_V);
    end
  end

  // R7: timeout only ever reported while data was present.
  a_r7_needs_data: assert property (@(posedge clk) disable iff (rst)
    tmo_irq |-> $past(rx_fill != '0));
  // R7: once raised, it holds while nothing disturbs it.
  a_r7_holds: assert property (@(posedge clk) disable iff (rst)
    (tmo_irq && !restart && !empty) |=> tmo_irq);
  // R8: a character or read clears it.
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!tmo_irq && idle_q == '0));
  // R9: an empty FIFO clears it.
  a_r9_empty_clears: assert property (@(posedge clk) disable iff (rst)
    empty |=> (!tmo_irq && idle_q == '0));

endmodule

// File: rtl/fifo_trig_irq.sv
module fifo_trig_irq
  import fti_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int TMO_CHARS = 4,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_free,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic [7:0]       trig_reg,
  input  logic [7:0]       fifo_ctl,
  input  logic             rx_char,
  input  logic             rx_read,
  input  logic             idle_tick,
  output logic             tx_ready_irq,
  output logic             rx_ready_irq,
  output logic             rx_timeout_irq
);

  logic [CNT_W-1:0] tx_level;
  logic [CNT_W-1:0] rx_level;

  fti_level_sel #(.CNT_W(CNT_W), .SIDE(SIDE_TX)) u_tx_sel (
    .nibble     (trig_reg[3:0]),
    .legacy_sel (fifo_ctl[5:4]),
    .level      (tx_level)
  );

  fti_level_sel #(.CNT_W(CNT_W), .SIDE(SIDE_RX)) u_rx_sel (
    .nibble     (trig_reg[7:4]),
    .legacy_sel (fifo_ctl[7:6]),
    .level      (rx_level)
  );

  fti_cmp #(.CNT_W(CNT_W)) u_tx_cmp (
    .clk (clk), .rst (rst), .count (tx_free), .level (tx_level), .irq (tx_ready_irq)
  );

  fti_cmp #(.CNT_W(CNT_W)) u_rx_cmp (
    .clk (clk), .rst (rst), .count (rx_fill), .level (rx_level), .irq (rx_ready_irq)
  );

  fti_rx_timeout #(.CNT_W(CNT_W), .TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk       (clk),
    .rst       (rst),
    .rx_fill   (rx_fill),
    .rx_char   (rx_char),
    .rx_read   (rx_read),
    .idle_tick (idle_tick),
    .tmo_irq   (rx_timeout_irq)
  );

  // R1/R2/R5/R6: every selected level is a legal multiple of four in 4..60.
  a_r1_tx_level_legal: assert property (@(posedge clk) disable iff (rst)
    (tx_level >= CNT_W'(4)) && (tx_level <= CNT_W'(60)) && (tx_level[1:0] == 2'b00));
  a_r2_rx_level_legal: assert property (@(posedge clk) disable iff (rst)
    (rx_level >= CNT_W'(4)) && (rx_level <= CNT_W'(60)) && (rx_level[1:0] == 2'b00));
  // R10: outputs cleared by reset.
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!tx_ready_irq && !rx_ready_irq && !rx_timeout_irq));

endmodule

// File: tb/tb_fifo_trig_irq.sv
`timescale 1ns/1ps
module tb_fifo_trig_irq;

  localparam int CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] tx_free = '0;
  logic [CNT_W-1:0] rx_fill = '0;
  logic [7:0]       trig_reg = '0;
  logic [7:0]       fifo_ctl = '0;
  logic             rx_char = 1'b0;
  logic             rx_read = 1'b0;
  logic             idle_tick = 1'b0;
  logic             tx_ready_irq, rx_ready_irq, rx_timeout_irq;

  always #2.5 clk = ~clk;

  fifo_trig_irq dut (
    .clk (clk), .rst (rst), .tx_free (tx_free), .rx_fill (rx_fill),
    .trig_reg (trig_reg), .fifo_ctl (fifo_ctl), .rx_char (rx_char),
    .rx_read (rx_read), .idle_tick (idle_tick), .tx_ready_irq (tx_ready_irq),
    .rx_ready_irq (rx_ready_irq), .rx_timeout_irq (rx_timeout_irq)
  );

  typedef struct {
    logic  tx;
    logic  rx;
    logic  tmo;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  int   m_idle = 0;   // bench model of the idle count
  bit   done   = 1'b0;

  function automatic int tx_lvl(input logic [7:0] t, input logic [7:0] f);
    int tab[4] = '{8, 16, 32, 56};
    if (t[3:0] != 0) return 4 * int'(t[3:0]);
    return tab[f[5:4]];
  endfunction

  function automatic int rx_lvl(input logic [7:0] t, input logic [7:0] f);
    int tab[4] = '{8, 16, 56, 60};
    if (t[7:4] != 0) return 4 * int'(t[7:4]);
    return tab[f[7:6]];
  endfunction

  // Driver: apply one cycle of stimulus, push the expected result.
  task automatic apply(input int tf, input int rf, input logic [7:0] t,
                       input logic [7:0] f, input logic ch, input logic rd,
                       input logic tk, input string tag);
    exp_t e;
    @(negedge clk);
    tx_free = CNT_W'(tf); rx_fill = CNT_W'(rf);
    trig_reg = t; fifo_ctl = f;
    rx_char = ch; rx_read = rd; idle_tick = tk;
    if (rf == 0 || ch || rd) m_idle = 0;
    else if (tk && m_idle < 4) m_idle++;
    e.tx  = (tf >= tx_lvl(t, f));
    e.rx  = (rf >= rx_lvl(t, f));
    e.tmo = (m_idle == 4);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after the edge that registered the stimulus.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (tx_ready_irq !== e.tx) begin
        n_fail++;
        $display("FAIL %s tx_ready_irq act=%b exp=%b", e.tag, tx_ready_irq, e.tx);
      end
      if (rx_ready_irq !== e.rx) begin
        n_fail++;
        $display("FAIL %s rx_ready_irq act=%b exp=%b", e.tag, rx_ready_irq, e.rx);
      end
      if (rx_timeout_irq !== e.tmo) begin
        n_fail++;
        $display("FAIL %s rx_timeout_irq act=%b exp=%b", e.tag, rx_timeout_irq, e.tmo);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    // R10: hold reset with counts above every level, outputs must be 0.
    tx_free = 7'd64; rx_fill = 7'd64; trig_reg = 8'h11;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (tx_ready_irq !== 1'b0 || rx_ready_irq !== 1'b0 || rx_timeout_irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset outputs act=%b%b%b exp=000",
               tx_ready_irq, rx_ready_irq, rx_timeout_irq);
    end
    @(negedge clk);
    rst = 1'b0;
    tx_free = '0; rx_fill = '0; trig_reg = '0;

    // R1 / R3: fine TX levels at the boundaries.
    apply(19, 0, 8'h05, 8'h00, 0, 0, 0, "R1 R3 tx lvl20 below");
    apply(20, 0, 8'h05, 8'h00, 0, 0, 0, "R1 R3 tx lvl20 at");
    apply(64, 0, 8'h05, 8'h00, 0, 0, 0, "R3 tx lvl20 full");
    apply(3,  0, 8'h01, 8'h00, 0, 0, 0, "R1 tx lvl4 below");
    apply(4,  0, 8'h01, 8'h00, 0, 0, 0, "R1 tx lvl4 at");
    apply(59, 0, 8'h0F, 8'hC0, 0, 0, 0, "R1 tx lvl60 below");
    apply(60, 0, 8'h0F, 8'hC0, 0, 0, 0, "R1 tx lvl60 at");

    // R2 / R4: fine RX levels (data present, no idle strobes).
    apply(0, 39, 8'hA0, 8'h00, 1, 0, 0, "R2 R4 rx lvl40 below");
    apply(0, 40, 8'hA0, 8'h00, 1, 0, 0, "R2 R4 rx lvl40 at");
    apply(0, 3,  8'h10, 8'h30, 0, 1, 0, "R2 rx lvl4 below");
    apply(0, 4,  8'h10, 8'h30, 0, 1, 0, "R2 rx lvl4 at");
    apply(0, 60, 8'hF0, 8'h00, 0, 1, 0, "R2 rx lvl60 at");

    // R5 / R6: legacy selections on both sides of each level.
    for (int s = 0; s < 4; s++) begin
      logic [7:0] f;
      int tl, rl;
      f  = {2'(s), 2'(3 - s), 4'h0};
      tl = tx_lvl(8'h00, f);
      rl = rx_lvl(8'h00, f);
      apply(tl - 1, rl - 1, 8'h00, f, 0, 1, 0, "R5 R6 legacy below");
      apply(tl,     rl,     8'h00, f, 0, 1, 0, "R5 R6 legacy at");
    end
    // Fine nibble on one side only while the other falls back.
    apply(31, 55, 8'h02, 8'h80, 0, 1, 0, "R1 R6 mixed");
    apply(32, 56, 8'h20, 8'h20, 0, 1, 0, "R2 R5 mixed");

    // R7: timeout with RX level 60 far above one byte.
    apply(0, 1, 8'hF0, 8'h00, 1, 0, 0, "R8 arm");
    apply(0, 1, 8'hF0, 8'h00, 0, 0, 1, "R7 tick1");
    apply(0, 1, 8'hF0, 8'h00, 0, 0, 0, "R7 gap");
    apply(0, 1, 8'hF0, 8'h00, 0, 0, 1, "R7 tick2");
    apply(0, 1, 8'hF0, 8'h00, 0, 0, 1, "R7 tick3");
    apply(0, 1, 8'hF0, 8'h00, 0, 0, 0, "R7 no fire at 3");
    apply(0, 1, 8'hF0, 8'h00, 0, 0, 1, "R7 tick4 fires");
    apply(0, 1, 8'hF0, 8'h00, 0, 0, 1, "R7 holds");
    apply(0, 1, 8'hF0, 8'h00, 0, 0, 0, "R7 holds idle");
    // R8: a read restarts the count.
    apply(0, 1, 8'hF0, 8'h00, 0, 1, 1, "R8 read clears");
    for (int k = 0; k < 3; k++)
      apply(0, 1, 8'hF0, 8'h00, 0, 0, 1, "R8 recount");
    apply(0, 1, 8'hF0, 8'h00, 1, 0, 1, "R8 char clears");
    for (int k = 0; k < 4; k++)
      apply(0, 2, 8'hF0, 8'h00, 0, 0, 1, "R7 refire");
    // R9: emptying clears, and ticks on an empty FIFO do nothing.
    apply(0, 0, 8'hF0, 8'h00, 0, 0, 1, "R9 empty clears");
    for (int k = 0; k < 5; k++)
      apply(0, 0, 8'hF0, 8'h00, 0, 0, 1, "R9 empty ticks");
    apply(0, 1, 8'hF0, 8'h00, 0, 0, 0, "R9 refill");
    for (int k = 0; k < 4; k++)
      apply(0, 1, 8'hF0, 8'h00, 0, 0, 1, "R9 count from zero");
    // R7 with RX level met too: independent flags.
    apply(0, 8, 8'h20, 8'h00, 0, 0, 1, "R7 R4 both");

    // R10: reset mid-run clears everything.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    n_vec++;
    if (tx_ready_irq !== 1'b0 || rx_ready_irq !== 1'b0 || rx_timeout_irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 mid-run reset act=%b%b%b exp=000",
               tx_ready_irq, rx_ready_irq, rx_timeout_irq);
    end
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule